// File: doc/BRIEF.md
# Backward-Branch Loop Profiler

This block sits beside a processor's instruction-fetch bus and watches the fetch addresses without taking part in the traffic. It has no ready signal and no output toward the bus: every cycle with `fetch_valid` high is consumed as it happens, so the processor can never be stalled or have its fetches altered. When a valid fetch address is below the previous valid fetch address, the block takes this as a taken backward branch, which is the signature of a loop. The source of the branch is the earlier address and the target is the later one.

Each detected branch updates a small fully associative table. The table is keyed by source address and holds the target and a saturating taken-count for each branch. A combinational query output always presents the hottest branch. Downstream logic can read it at any time to pick the loop most worth moving into hardware. The default table has 16 entries with 16-bit counters and 32-bit word-aligned addresses.

Top module: `loop_profiler`

## Requirements
- R1: A backward branch is detected in a cycle where `fetch_valid` is high, `clear` is low, and `fetch_addr` is strictly below the address of the most recent earlier valid fetch, even when idle cycles lie between the two. The first valid fetch after reset or after `clear` is never a branch.
- R2: Cycles with `fetch_valid` low, forward fetches and fetches to an equal address leave the table unchanged.
- R3: A branch whose source is already in the table increments that entry's count by one. The new count is visible on the query outputs in the cycle after the branch fetch.
- R4: A branch whose source is not in the table is written with its source, its target and a count of 1. It goes into the lowest-index empty entry. If the table is full, it replaces the entry with the lowest count, and the lowest index wins ties.
- R5: A hit on an entry whose count is already at its maximum (all ones) does not increment. Instead, every count in the table is shifted right by one in that single update.
- R6: `hot_src`, `hot_tgt` and `hot_count` show the valid entry with the highest count, and the lowest index wins ties. `hot_valid` is high exactly when at least one entry is valid. When the table is empty, all query fields read zero.
- R7: A cycle with `clear` high empties every entry and forgets the last fetch address. A fetch made in that same cycle is ignored.
- R8: After reset the table is empty and `hot_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous table clear |
| fetch_valid | input | 1 | A fetch address is present on the bus |
| fetch_addr | input | 32 | Observed instruction-fetch address |
| hot_valid | output | 1 | Table holds at least one entry |
| hot_src | output | 32 | Source address of the hottest branch |
| hot_tgt | output | 32 | Target address of the hottest branch |
| hot_count | output | CNT_W | Count of the hottest branch |

## Verification
The hardest state to reach from the ports is a full table in which one counter sits at its maximum while the others hold small, differing counts. Only in that state do the halving rule and the eviction rule act together. The stimulus instantiates the block with four entries and 4-bit counters. It fills the table with loops of unequal heat, forces an eviction, and then drives one loop until its counter tops out. One more hit then triggers the halving. A miss follows, so that the eviction must choose among entries that the halving has just reduced to zero.

// File: rtl/lp_pkg.sv
package lp_pkg;
  localparam int ADDR_W = 32;
  typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/lp_branch_detect.sv
module lp_branch_detect
  import lp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clear,
  input  logic  fetch_valid,
  input  addr_t fetch_addr,
  output logic  br_valid,
  output addr_t br_src,
  output addr_t br_tgt
);
  addr_t last_addr;
  logic  last_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_addr <= '0;
      last_ok   <= 1'b0;
    end else if (clear) begin
      last_ok   <= 1'b0;
    end else if (fetch_valid) begin
      last_addr <= fetch_addr;
      last_ok   <= 1'b1;
    end
  end

  assign br_valid = fetch_valid && !clear && last_ok && (fetch_addr < last_addr);
  assign br_src   = last_addr;
  assign br_tgt   = fetch_addr;

  // R1
  last_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !clear) |=> (last_ok && last_addr == $past(fetch_addr)));
  // R7
  forget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !last_ok);
endmodule

// File: rtl/lp_rank_select.sv
module lp_rank_select #(
  parameter int N        = 16,
  parameter int CW       = 16,
  parameter bit FIND_MAX = 1'b1,
  localparam int IW      = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]         valid,
  input  logic [N-1:0][CW-1:0] cnt,
  output logic                 found,
  output logic [IW-1:0]        idx
);
  logic [CW-1:0] best;

  function automatic logic beats(input logic [CW-1:0] a, input logic [CW-1:0] b);
    if (FIND_MAX) return a > b;
    else          return a < b;
  endfunction

  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < N; i++) begin
      if (valid[i] && (!found || beats(cnt[i], best))) begin
        found = 1'b1;
        idx   = IW'(i);
        best  = cnt[i];
      end
    end
  end
endmodule

// File: rtl/lp_entry_cache.sv
module lp_entry_cache
  import lp_pkg::*;
#(
  parameter int N   = 16,
  parameter int CW  = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     br_valid,
  input  addr_t                    br_src,
  input  addr_t                    br_tgt,
  output logic [N-1:0]             valid_q,
  output logic [N-1:0][ADDR_W-1:0] src_q,
  output logic [N-1:0][ADDR_W-1:0] tgt_q,
  output logic [N-1:0][CW-1:0]     cnt_q
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [N-1:0]  match;
  logic          hit, any_free, victim_found;
  logic [IW-1:0] hit_idx, free_idx, victim_idx, ins_idx;

  for (genvar g = 0; g < N; g++) begin : g_match
    assign match[g] = valid_q[g] && (src_q[g] == br_src);
  end

  always_comb begin
    hit = 1'b0; hit_idx = '0; any_free = 1'b0; free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i])    begin hit = 1'b1;      hit_idx = IW'(i);  end
      if (!valid_q[i]) begin any_free = 1'b1; free_idx = IW'(i); end
    end
  end

  lp_rank_select #(.N(N), .CW(CW), .FIND_MAX(1'b0)) i_victim (
    .valid (valid_q),
    .cnt   (cnt_q),
    .found (victim_found),
    .idx   (victim_idx)
  );

  assign ins_idx = any_free ? free_idx : victim_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      src_q   <= '0;
      tgt_q   <= '0;
      cnt_q   <= '0;
    end else if (clear) begin
      valid_q <= '0;
      cnt_q   <= '0;
    end else if (br_valid) begin
      if (hit) begin
        if (cnt_q[hit_idx] == CNT_MAX) begin
          for (int i = 0; i < N; i++) cnt_q[i] <= cnt_q[i] >> 1;
        end else begin
          cnt_q[hit_idx] <= cnt_q[hit_idx] + CW'(1);
        end
      end else begin
        valid_q[ins_idx] <= 1'b1;
        src_q[ins_idx]   <= br_src;
        tgt_q[ins_idx]   <= br_tgt;
        cnt_q[ins_idx]   <= CW'(1);
      end
    end
  end

  // R2
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_valid && !clear) |=> ($stable(valid_q) && $stable(cnt_q) && $stable(src_q)));
  // R3
  hit_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && hit && !clear && cnt_q[hit_idx] != CNT_MAX)
      |=> cnt_q[$past(hit_idx)] == $past(cnt_q[hit_idx]) + CW'(1));
  // R4
  miss_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !hit && !clear)
      |=> (valid_q[$past(ins_idx)] && cnt_q[$past(ins_idx)] == CW'(1)
           && src_q[$past(ins_idx)] == $past(br_src)));
  // R4
  victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q == '1) |-> victim_found);
  // R5
  halve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && hit && !clear && cnt_q[hit_idx] == CNT_MAX)
      |=> cnt_q[$past(hit_idx)] == (CNT_MAX >> 1));
  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (valid_q == '0));
endmodule

// File: rtl/loop_profiler.sv
module loop_profiler
  import lp_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              fetch_valid,
  input  logic [31:0]       fetch_addr,
  output logic              hot_valid,
  output logic [31:0]       hot_src,
  output logic [31:0]       hot_tgt,
  output logic [CNT_W-1:0]  hot_count
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic                           br_valid;
  addr_t                          br_src, br_tgt;
  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0][ADDR_W-1:0] src_q, tgt_q;
  logic [ENTRIES-1:0][CNT_W-1:0]  cnt_q;
  logic                           top_found;
  logic [IW-1:0]                  top_idx;

  lp_branch_detect i_detect (
    .clk, .rst_n, .clear, .fetch_valid, .fetch_addr,
    .br_valid, .br_src, .br_tgt
  );

  lp_entry_cache #(.N(ENTRIES), .CW(CNT_W)) i_cache (
    .clk, .rst_n, .clear, .br_valid, .br_src, .br_tgt,
    .valid_q, .src_q, .tgt_q, .cnt_q
  );

  lp_rank_select #(.N(ENTRIES), .CW(CNT_W), .FIND_MAX(1'b1)) i_hottest (
    .valid (valid_q),
    .cnt   (cnt_q),
    .found (top_found),
    .idx   (top_idx)
  );

  assign hot_valid = top_found;
  assign hot_src   = top_found ? src_q[top_idx] : '0;
  assign hot_tgt   = top_found ? tgt_q[top_idx] : '0;
  assign hot_count = top_found ? cnt_q[top_idx] : '0;

  // R6
  hot_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hot_valid == (valid_q != '0));
  // R8
  reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !hot_valid);
endmodule

// File: tb/test_loop_profiler.sv
module test_loop_profiler;
  localparam int N  = 4;
  localparam int CW = 4;
  localparam logic [CW-1:0] MAXC = {CW{1'b1}};

  logic clk = 1'b0, rst_n = 1'b0, clear = 1'b0, fetch_valid = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic hot_valid;
  logic [31:0] hot_src, hot_tgt;
  logic [CW-1:0] hot_count;

  always #5 clk = ~clk;

  loop_profiler #(.ENTRIES(N), .CNT_W(CW)) i_loop_profiler (
    .clk, .rst_n, .clear, .fetch_valid, .fetch_addr,
    .hot_valid, .hot_src, .hot_tgt, .hot_count
  );

  int checks = 0, fails = 0;

  logic        mv [N];
  logic [31:0] ms [N], mt [N];
  logic [CW-1:0] mc [N];

  typedef struct { logic v; logic [31:0] s; logic [31:0] t; logic [CW-1:0] c; string req; } exp_t;
  exp_t exp_q[$];

  task automatic compare(input exp_t e);
    checks++;
    if (hot_valid !== e.v || hot_src !== e.s || hot_tgt !== e.t || hot_count !== e.c) begin
      fails++;
      $display("FAIL %s: got v=%0b src=%h tgt=%h cnt=%0d, expected v=%0b src=%h tgt=%h cnt=%0d",
               e.req, hot_valid, hot_src, hot_tgt, hot_count, e.v, e.s, e.t, e.c);
    end
  endtask

  function automatic exp_t model_hot(input string req);
    exp_t e; int b = -1;
    for (int i = 0; i < N; i++)
      if (mv[i] && (b < 0 || mc[i] > mc[b])) b = i;
    e.req = req;
    if (b < 0) begin e.v = 0; e.s = 0; e.t = 0; e.c = 0; end
    else begin e.v = 1; e.s = ms[b]; e.t = mt[b]; e.c = mc[b]; end
    return e;
  endfunction

  task automatic model_branch(input logic [31:0] s, input logic [31:0] t);
    int h = -1, f = -1, v = -1;
    for (int i = 0; i < N; i++) begin
      if (mv[i] && ms[i] == s && h < 0) h = i;
      if (!mv[i] && f < 0) f = i;
      if (mv[i] && (v < 0 || mc[i] < mc[v])) v = i;
    end
    if (h >= 0) begin
      if (mc[h] == MAXC) for (int i = 0; i < N; i++) mc[i] = mc[i] >> 1;
      else mc[h] = mc[h] + 1'b1;
    end else begin
      if (f < 0) f = v;
      mv[f] = 1; ms[f] = s; mt[f] = t; mc[f] = 1;
    end
  endtask

  task automatic fetch(input logic [31:0] a, input int gap);
    fetch_valid = 1'b1; fetch_addr = a;
    @(negedge clk);
    fetch_valid = 1'b0; fetch_addr = '0;
    repeat (gap) @(negedge clk);
  endtask

  // driver: source fetch, optional idle gap, target fetch, then expected result
  task automatic branch(input logic [31:0] s, input logic [31:0] t, input int gap, input string req);
    fetch(s, gap);
    fetch(t, 0);
    model_branch(s, t);
    exp_q.push_back(model_hot(req));
  endtask

  // monitor
  always @(negedge clk) begin
    #1;
    while (exp_q.size() > 0) compare(exp_q.pop_front());
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin mv[i] = 0; ms[i] = 0; mt[i] = 0; mc[i] = 0; end
    repeat (3) @(negedge clk);
    exp_q.push_back(model_hot("R8 reset empty"));
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: branch seen across idle cycles
    branch(32'h300, 32'h50, 3, "R1 backward across gap");
    // R2: forward, equal and invalid low cycles do nothing
    fetch(32'h60, 0); fetch(32'h70, 0); fetch(32'h70, 0);
    fetch_addr = 32'h4; @(negedge clk); fetch_addr = '0;
    exp_q.push_back(model_hot("R2 forward/equal/invalid ignored"));
    @(negedge clk);
    // R3: repeated hits
    branch(32'h300, 32'h50, 0, "R3 hit count 2");
    branch(32'h300, 32'h50, 0, "R3 hit count 3");
    // R4: fill free entries in order
    branch(32'h100, 32'h10, 0, "R4 fill entry 1");
    branch(32'h200, 32'h20, 0, "R4 fill entry 2");
    branch(32'h400, 32'h40, 0, "R4 fill entry 3");
    branch(32'h100, 32'h10, 0, "R3 hit second loop");
    // R6: tie at count 3 goes to the lowest index
    branch(32'h100, 32'h10, 0, "R6 tie lowest index");
    // R4: full table, evict lowest count / lowest index
    branch(32'h500, 32'h30, 0, "R4 evict min");
    branch(32'h200, 32'h20, 0, "R4 evicted loop returns as new");
    branch(32'h100, 32'h10, 0, "R6 new leader");
    // R5: drive loop to saturation then once more
    while (mc[1] != MAXC) branch(32'h100, 32'h10, 0, "R3 climb");
    branch(32'h100, 32'h10, 0, "R5 halve on saturated hit");
    branch(32'h600, 32'h08, 0, "R4 evict after halving");
    // R7: clear empties and forgets last address
    fetch(32'h700, 0);
    clear = 1'b1; @(negedge clk); clear = 1'b0;
    for (int i = 0; i < N; i++) mv[i] = 0;
    exp_q.push_back(model_hot("R7 clear empties"));
    @(negedge clk);
    fetch(32'h20, 0);
    exp_q.push_back(model_hot("R7 no branch from stale address"));
    @(negedge clk);
    branch(32'h90, 32'h44, 0, "R7 detection resumes");
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule